// File: doc/BRIEF.md
# Unaligned Quad-Word Read Aligner

This block lets a register file read four consecutive 32-bit words from any word address, even though the memory behind it can only return four-word groups whose first address is a multiple of four. It holds up to four pointer registers. Each accepted read request fetches the aligned group that contains the selected pointer and then advances that pointer by four words. The block keeps the group from the previous fetch and shifts the previous and current groups together. The result is the four words that start at the pointer used by the previous request.

Because of this, the block acts as one extra stage in the read path. After a pointer is loaded, the first read only primes the stored group, and its result is not marked valid. Every later read returns the data for the read before it. When a nonzero circular length is set, each pointer update stays inside the region that starts at the base and spans the length. The stored group is shared, so a pointer load also flushes it.

Top module: `quad_align_buf`

## Requirements
- R1: An accepted read drives `memRd` high in the request cycle, with `memQuadAddr` equal to the selected pointer shifted right by two. The memory returns that group on `memData` in the next cycle. The word at group offset j sits in bits [32j+31:32j], and output lanes use the same packing.
- R2: Each accepted read post-increments the selected pointer by four words, so consecutive reads on one pointer fetch consecutive groups.
- R3: For every accepted read after the priming read, `outValid` is high two cycles after the request. `outData` then holds the four words that start at the pointer value of the previous accepted read.
- R4: When the previous pointer was aligned, `outData` equals the previously fetched group unchanged, and the same two-cycle timing applies.
- R5: The first accepted read after a pointer load or reset is a priming read: no `outValid` pulse follows it.
- R6: Synchronous reset clears all pointers to zero and drops `outValid` and `outErr`. The first read after reset fetches group 0 and is a priming read.
- R7: A pointer load flushes the stored group. The next read is a priming read again, even in the middle of a stream.
- R8: With `cfgLen` nonzero, the next pointer is p+4-`cfgLen` whenever p+4 >= `cfgBase`+`cfgLen`, and p+4 otherwise. With `cfgLen` zero, it is always p+4.
- R9: A read that selects an index from 4 to 7 is rejected. `outErr` pulses one cycle later, no fetch is issued, no pointer moves, and the stored group is kept.
- R10: Loading one pointer leaves the other pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ldEn | input | 1 | Load a pointer register; takes priority over a read in the same cycle |
| ldSel | input | 3 | Pointer index to load |
| ldAddr | input | 10 | Word address to load |
| rdReq | input | 1 | Read request |
| rdSel | input | 3 | Pointer index used by the read |
| cfgBase | input | 10 | Circular region base (word address) |
| cfgLen | input | 10 | Circular region length in words; zero disables wrapping |
| memRd | output | 1 | Aligned group fetch strobe |
| memQuadAddr | output | 8 | Aligned group index |
| memData | input | 128 | Group returned by memory one cycle after `memRd` |
| outValid | output | 1 | Result strobe |
| outData | output | 128 | Four merged words, lowest address in lane 0 |
| outErr | output | 1 | Rejected-index strobe |

## Verification
The sweeps cover every start offset on every pointer and several circular lengths, including lengths that are not a multiple of four. A shifter that picked the current group instead of the previous one, or that used the new offset in place of the old, would give data one group off or rotated. A design that skipped priming would pulse `outValid` after the first read. A design that kept its stored group across a load would return stale words instead of staying silent. Rejected indices must leave the stream intact, so a design that advanced a pointer or captured a group on an error would break the next comparison.

// File: rtl/qab_pkg.sv
package qab_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic capture;  // memData holds the group fetched last cycle
    logic flush;    // forget the stored group
  } dpStrobe_t;

endpackage

// File: rtl/qab_next_ptr.sv
module qab_next_ptr #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic [ADDR_W-1:0] curPtr,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgLen,
  output logic [ADDR_W-1:0] nextPtr
);

  localparam int SUM_W = ADDR_W + 1;

  logic [SUM_W-1:0] stepSum;
  logic [SUM_W-1:0] regionEnd;
  logic [SUM_W-1:0] wrapped;
  logic             circOn;
  logic             pastEnd;

  assign stepSum   = {1'b0, curPtr} + SUM_W'(LANES);
  assign regionEnd = {1'b0, cfgBase} + {1'b0, cfgLen};
  assign circOn    = (cfgLen != '0);
  assign pastEnd   = (stepSum >= regionEnd);
  assign wrapped   = stepSum - {1'b0, cfgLen};

  assign nextPtr = (circOn && pastEnd) ? wrapped[ADDR_W-1:0] : stepSum[ADDR_W-1:0];

endmodule

// File: rtl/qab_ctrl.sv
module qab_ctrl
  import qab_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int SEL_W  = 3,
  parameter int NPTR   = 4,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ldEn,
  input  logic [SEL_W-1:0]          ldSel,
  input  logic [ADDR_W-1:0]         ldAddr,
  input  logic                      rdReq,
  input  logic [SEL_W-1:0]          rdSel,
  input  logic [ADDR_W-1:0]         cfgBase,
  input  logic [ADDR_W-1:0]         cfgLen,
  output logic                      memRd,
  output logic [ADDR_W-$clog2(LANES)-1:0] memQuadAddr,
  output logic                      outValid,
  output logic                      outErr,
  output dpStrobe_t                 strobe,
  output logic [$clog2(LANES)-1:0]  mergeOff
);

  localparam int OFF_W  = $clog2(LANES);
  localparam int PIDX_W = (NPTR > 1) ? $clog2(NPTR) : 1;

  logic [ADDR_W-1:0] ptrQ [NPTR];
  logic [ADDR_W-1:0] curPtr;
  logic [ADDR_W-1:0] stepPtr;
  logic              selOk;
  logic              accept;
  logic              s1Valid;
  logic [OFF_W-1:0]  s1Off;
  logic [OFF_W-1:0]  prevOff;
  logic              primed;

  assign selOk  = ({1'b0, rdSel} < (SEL_W+1)'(NPTR));
  assign curPtr = ptrQ[rdSel[PIDX_W-1:0]];
  assign accept = rdReq && selOk && !ldEn;

  qab_next_ptr #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES)
  ) u_next (
    .curPtr  (curPtr),
    .cfgBase (cfgBase),
    .cfgLen  (cfgLen),
    .nextPtr (stepPtr)
  );

  // One register per pointer; loads win over steps.
  for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst) begin
        ptrQ[gi] <= '0;
      end else if (ldEn && (ldSel == SEL_W'(gi))) begin
        ptrQ[gi] <= ldAddr;
      end else if (accept && (rdSel == SEL_W'(gi))) begin
        ptrQ[gi] <= stepPtr;
      end
    end
  end

  assign memRd       = accept;
  assign memQuadAddr = curPtr[ADDR_W-1:OFF_W];

  // Fetch-return stage and buffer state.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid  <= 1'b0;
      s1Off    <= '0;
      prevOff  <= '0;
      primed   <= 1'b0;
      outValid <= 1'b0;
      outErr   <= 1'b0;
    end else begin
      s1Valid  <= accept;
      if (accept) begin
        s1Off <= curPtr[OFF_W-1:0];
      end
      if (s1Valid) begin
        prevOff <= s1Off;
      end
      if (ldEn) begin
        primed <= 1'b0;
      end else if (s1Valid) begin
        primed <= 1'b1;
      end
      outValid <= s1Valid && primed;
      outErr   <= rdReq && !selOk && !ldEn;
    end
  end

  assign strobe.capture = s1Valid;
  assign strobe.flush   = ldEn;
  assign mergeOff       = prevOff;

endmodule

// File: rtl/qab_datapath.sv
module qab_datapath
  import qab_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LANES  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  dpStrobe_t                  strobe,
  input  logic [$clog2(LANES)-1:0]   mergeOff,
  input  logic [WORD_W*LANES-1:0]    memData,
  output logic [WORD_W*LANES-1:0]    outData
);

  localparam int OFF_W  = $clog2(LANES);
  localparam int IDX_W  = OFF_W + 1;
  localparam int QUAD_W = WORD_W * LANES;

  logic [QUAD_W-1:0] prevQuad;
  logic [QUAD_W-1:0] merged;
  logic [WORD_W-1:0] catW [2*LANES];

  // Previous group occupies the lower addresses, the fresh group the upper.
  for (genvar gj = 0; gj < LANES; gj++) begin : g_cat
    assign catW[gj]         = prevQuad[gj*WORD_W +: WORD_W];
    assign catW[gj + LANES] = memData[gj*WORD_W +: WORD_W];
  end

  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    logic [IDX_W-1:0] pick;
    assign pick = {1'b0, mergeOff} + IDX_W'(gl);
    assign merged[gl*WORD_W +: WORD_W] = catW[pick];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevQuad <= '0;
      outData  <= '0;
    end else begin
      if (strobe.capture) begin
        outData <= merged;
      end
      if (strobe.flush) begin
        prevQuad <= '0;
      end else if (strobe.capture) begin
        prevQuad <= memData;
      end
    end
  end

endmodule

// File: rtl/quad_align_buf.sv
module quad_align_buf
  import qab_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LANES  = 4,
  parameter int ADDR_W = 10,
  parameter int SEL_W  = 3,
  parameter int NPTR   = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              ldEn,
  input  logic [SEL_W-1:0]                  ldSel,
  input  logic [ADDR_W-1:0]                 ldAddr,
  input  logic                              rdReq,
  input  logic [SEL_W-1:0]                  rdSel,
  input  logic [ADDR_W-1:0]                 cfgBase,
  input  logic [ADDR_W-1:0]                 cfgLen,
  output logic                              memRd,
  output logic [ADDR_W-$clog2(LANES)-1:0]   memQuadAddr,
  input  logic [WORD_W*LANES-1:0]           memData,
  output logic                              outValid,
  output logic [WORD_W*LANES-1:0]           outData,
  output logic                              outErr
);

  localparam int OFF_W = $clog2(LANES);

  dpStrobe_t        strobe;
  logic [OFF_W-1:0] mergeOff;

  qab_ctrl #(
    .ADDR_W (ADDR_W),
    .SEL_W  (SEL_W),
    .NPTR   (NPTR),
    .LANES  (LANES)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .ldEn        (ldEn),
    .ldSel       (ldSel),
    .ldAddr      (ldAddr),
    .rdReq       (rdReq),
    .rdSel       (rdSel),
    .cfgBase     (cfgBase),
    .cfgLen      (cfgLen),
    .memRd       (memRd),
    .memQuadAddr (memQuadAddr),
    .outValid    (outValid),
    .outErr      (outErr),
    .strobe      (strobe),
    .mergeOff    (mergeOff)
  );

  qab_datapath #(
    .WORD_W (WORD_W),
    .LANES  (LANES)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .mergeOff (mergeOff),
    .memData  (memData),
    .outData  (outData)
  );

endmodule

// File: rtl/quad_align_buf_chk.sv
module quad_align_buf_chk #(
  parameter int ADDR_W = 10,
  parameter int SEL_W  = 3,
  parameter int NPTR   = 4,
  parameter int QA_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ldEn,
  input logic              rdReq,
  input logic [SEL_W-1:0]  rdSel,
  input logic [ADDR_W-1:0] cfgLen,
  input logic              memRd,
  input logic [QA_W-1:0]   memQuadAddr,
  input logic              outValid,
  input logic              outErr
);

  // R9: an error pulse only follows a request with an out-of-range index
  a_r9_err_cause: assert property (@(posedge clk) disable iff (rst)
    outErr |-> ($past(rdReq) && ($past(rdSel) >= SEL_W'(NPTR))));

  // R9: a rejected request issued no fetch
  a_r9_no_fetch: assert property (@(posedge clk) disable iff (rst)
    outErr |-> !$past(memRd));

  // R3: a valid result always traces back to a fetch two cycles earlier
  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(memRd, 2));

  // R7: a load leaves no valid result in the cycle after next
  a_r7_load_flush: assert property (@(posedge clk) disable iff (rst)
    ldEn |=> ##1 !outValid);

  // R2: back-to-back reads on one pointer without wrap fetch consecutive groups
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (memRd && $past(memRd) && (rdSel == $past(rdSel)) && (cfgLen == '0) && ($past(cfgLen) == '0))
      |-> (memQuadAddr == $past(memQuadAddr) + 1'b1));

endmodule

bind quad_align_buf quad_align_buf_chk #(
  .ADDR_W (ADDR_W),
  .SEL_W  (SEL_W),
  .NPTR   (NPTR),
  .QA_W   (ADDR_W - $clog2(LANES))
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ldEn        (ldEn),
  .rdReq       (rdReq),
  .rdSel       (rdSel),
  .cfgLen      (cfgLen),
  .memRd       (memRd),
  .memQuadAddr (memQuadAddr),
  .outValid    (outValid),
  .outErr      (outErr)
);

// File: tb/quad_align_buf_tb.sv
module quad_align_buf_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 32;
  localparam int LANES  = 4;
  localparam int ADDR_W = 10;
  localparam int SEL_W  = 3;
  localparam int NPTR   = 4;
  localparam int QUAD_W = WORD_W * LANES;
  localparam int QA_W   = ADDR_W - 2;
  localparam int AMASK  = (1 << ADDR_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ldEn = 1'b0;
  logic [SEL_W-1:0]  ldSel = '0;
  logic [ADDR_W-1:0] ldAddr = '0;
  logic              rdReq = 1'b0;
  logic [SEL_W-1:0]  rdSel = '0;
  logic [ADDR_W-1:0] cfgBase = '0;
  logic [ADDR_W-1:0] cfgLen = '0;
  logic              memRd;
  logic [QA_W-1:0]   memQuadAddr;
  logic [QUAD_W-1:0] memData = '0;
  logic              outValid;
  logic [QUAD_W-1:0] outData;
  logic              outErr;

  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;

  // Bench model state
  int  mp [NPTR];
  int  pq = 0;
  int  poff = 0;
  bit  primedM = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_align_buf #(
    .WORD_W (WORD_W), .LANES (LANES), .ADDR_W (ADDR_W), .SEL_W (SEL_W), .NPTR (NPTR)
  ) u_dut (
    .clk (clk), .rst (rst), .ldEn (ldEn), .ldSel (ldSel), .ldAddr (ldAddr),
    .rdReq (rdReq), .rdSel (rdSel), .cfgBase (cfgBase), .cfgLen (cfgLen),
    .memRd (memRd), .memQuadAddr (memQuadAddr), .memData (memData),
    .outValid (outValid), .outData (outData), .outErr (outErr)
  );

  function automatic logic [WORD_W-1:0] wordOf(int a);
    return (32'(a & AMASK) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [QUAD_W-1:0] quadOf(int q);
    logic [QUAD_W-1:0] r;
    for (int j = 0; j < LANES; j++) r[j*WORD_W +: WORD_W] = wordOf(q*4 + j);
    return r;
  endfunction

  function automatic logic [QUAD_W-1:0] expMerge(int prevQ, int curQ, int off);
    logic [QUAD_W-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      int idx = off + i;
      int a   = (idx < 4) ? prevQ*4 + idx : curQ*4 + idx - 4;
      r[i*WORD_W +: WORD_W] = wordOf(a);
    end
    return r;
  endfunction

  function automatic int nextOf(int p);
    int s = p + 4;
    int b = int'(cfgBase);
    int l = int'(cfgLen);
    if (l != 0 && s >= b + l) s = s - l;
    return s & AMASK;
  endfunction

  // Behavioural synchronous memory
  always @(posedge clk) if (memRd) memData <= quadOf(int'(memQuadAddr));

  task automatic chk(bit ok, string tag, logic [QUAD_W-1:0] act, logic [QUAD_W-1:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doLoad(int sel, int addr);
    ldEn = 1'b1; ldSel = SEL_W'(sel); ldAddr = ADDR_W'(addr);
    tick();
    ldEn = 1'b0;
    if (sel < NPTR) begin
      mp[sel] = addr & AMASK;
      primedM = 1'b0;
    end
  endtask

  task automatic doRead(int sel, string tag);
    bit good = (sel < NPTR);
    logic [QUAD_W-1:0] expD = '0;
    bit expV = 1'b0;
    rdReq = 1'b1; rdSel = SEL_W'(sel);
    #1;
    if (good) begin
      chk(memRd == 1'b1, "R1", QUAD_W'(memRd), QUAD_W'(1));
      chk(int'(memQuadAddr) == (mp[sel] >> 2), "R2", QUAD_W'(memQuadAddr), QUAD_W'(mp[sel] >> 2));
      expV = primedM;
      expD = expMerge(pq, mp[sel] >> 2, poff);
      pq = mp[sel] >> 2;
      poff = mp[sel] & 3;
      primedM = 1'b1;
      mp[sel] = nextOf(mp[sel]);
    end else begin
      chk(memRd == 1'b0, "R9", QUAD_W'(memRd), QUAD_W'(0));
    end
    tick();
    rdReq = 1'b0;
    chk(outErr == !good, "R9", QUAD_W'(outErr), QUAD_W'(!good));
    tick();
    if (!good) begin
      chk(outValid == 1'b0 && outErr == 1'b0, "R9", QUAD_W'({outValid, outErr}), QUAD_W'(0));
    end else if (!expV) begin
      chk(outValid == 1'b0, (tag == "R7") ? "R7" : "R5", QUAD_W'(outValid), QUAD_W'(0));
    end else begin
      chk(outValid == 1'b1, tag, QUAD_W'(outValid), QUAD_W'(1));
      chk(outData == expD, tag, outData, expD);
    end
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NPTR; i++) mp[i] = 0;
    repeat (3) tick();
    // R6: reset state
    chk(outValid == 1'b0 && outErr == 1'b0 && memRd == 1'b0, "R6",
        QUAD_W'({outValid, outErr, memRd}), QUAD_W'(0));
    rst = 1'b0;
    tick();
    // R6: first read from reset pointer fetches group 0 and only primes
    rdReq = 1'b1; rdSel = '0;
    #1;
    chk(memQuadAddr == '0, "R6", QUAD_W'(memQuadAddr), QUAD_W'(0));
    rdReq = 1'b0;
    doRead(0, "R6");
    doRead(0, "R6");

    // R3/R4/R1/R2: every start offset on every pointer
    for (int s = 0; s < NPTR; s++) begin
      for (int a = 0; a < 12; a++) begin
        doLoad(s, 64*s + 16 + a);
        for (int k = 0; k < 5; k++) doRead(s, (a % 4 == 0) ? "R4" : "R3");
      end
    end

    // R8: circular wrap with several lengths and starts
    cfgBase = ADDR_W'(200);
    foreach (mp[i]) begin end
    for (int li = 0; li < 3; li++) begin
      int len = (li == 0) ? 16 : (li == 1) ? 20 : 13;
      cfgLen = ADDR_W'(len);
      for (int a = 200; a < 200 + len; a += 3) begin
        doLoad(1, a);
        for (int k = 0; k < 7; k++) doRead(1, "R8");
      end
    end
    cfgLen = '0;

    // R9: rejected index keeps stream intact
    doLoad(0, 41);
    doRead(0, "R3");
    doRead(0, "R3");
    doRead(5, "R9");
    doRead(7, "R9");
    doRead(0, "R9");

    // R7: reload mid-stream forces a new priming read
    doLoad(0, 9);
    doRead(0, "R3");
    doRead(0, "R3");
    doLoad(0, 30);
    doRead(0, "R7");
    doRead(0, "R7");

    // R10: loading another pointer leaves this one alone
    doLoad(0, 301);
    doLoad(2, 502);
    doLoad(3, 7);
    doRead(0, "R10");
    doRead(0, "R10");
    doRead(0, "R10");

    // R3: back-to-back burst with wrap on pointer 3
    begin
      logic [QUAD_W-1:0] bExp [12];
      int p;
      int prevQ = 0;
      int prevO = 0;
      cfgBase = ADDR_W'(102);
      cfgLen  = ADDR_W'(22);
      doLoad(3, 110);
      p = 110;
      for (int k = 0; k < 12; k++) begin
        bExp[k] = expMerge(prevQ, p >> 2, prevO);
        prevQ = p >> 2;
        prevO = p & 3;
        p = nextOf(p);
      end
      fork
        begin
          for (int k = 0; k < 12; k++) begin
            rdReq = 1'b1; rdSel = 3'd3;
            tick();
          end
          rdReq = 1'b0;
        end
        begin
          tick();
          tick();
          for (int k = 0; k < 12; k++) begin
            if (k == 0) begin
              chk(outValid == 1'b0, "R5", QUAD_W'(outValid), QUAD_W'(0));
            end else begin
              chk(outValid == 1'b1, "R3", QUAD_W'(outValid), QUAD_W'(1));
              chk(outData == bExp[k], "R3", outData, bExp[k]);
            end
            tick();
          end
        end
      join
      cfgLen = '0;
    end

    tick();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule